// File: doc/BRIEF.md
# Two-Wire Register File Slave with Calibration ROM Window

This block is the control port of a configuration-driven device. It listens on a two-wire serial bus and answers one of three 7-bit slave addresses. A three-level strap input picks the address. Behind the bus sits a bank of byte-wide control registers. A bus master loads a register pointer and then either writes a run of consecutive registers or reads them back. For a read, the master sets the pointer in a write frame and then issues a repeated START with the read bit set. The contents of every writable register are driven out in parallel so that the rest of the device can use them.

A small calibration ROM is reached indirectly. The low nibble of one writable register chooses a ROM entry. That entry is copied into a read-only register on every clock, so a read of that register returns the selected entry. Two further read-only registers show live status inputs. Both bus lines are oversampled by the system clock. The only thing the block drives onto the bus is an enable that pulls SDA low. No data stream passes the block edge, so there is no valid/ready pair: all pins are plain levels.

Top module: `i2cr_slave`

## Requirements
- R1: After reset `sda_pull` is 0 and every field of `reg_flat` is 0x00. The slave never pulls SDA outside an addressed transaction.
- R2: The slave address is BASE_ADDR (7'h30) plus an offset set by `strap_lvl`: 2'b00 (driven low) gives +0, 2'b01 (driven high) gives +1, and 2'b10 or 2'b11 (floating) gives +2. A matching address byte is acknowledged by holding SDA low during the ninth clock. Any other address gets no acknowledge, and the rest of that transaction is ignored until the next START.
- R3: A write frame is the address byte with R/W=0, then a pointer byte, then data bytes. Every byte is acknowledged. Each data byte goes to the register at the pointer, and the pointer then advances by one.
- R4: After a repeated START with R/W=1, bytes are returned MSB first, starting at the pointer and advancing by one per byte. SDA changes only while SCL is low. A master ACK fetches the next byte, and a NACK ends the read.
- R5: Registers 0x00 to 0x0F are writable and read back their contents. Register n appears on `reg_flat[8n+7:8n]`.
- R6: Register 0x10 returns ROM entry i, where i is bits [3:0] of register 0x0E. Entry i holds (i*37+27) mod 256 for i < 13, and indices 13 to 15 read 0x00.
- R7: Register 0x11 returns `vco_stat` and register 0x12 returns `gen_stat`, both sampled at the time of the read.
- R8: Writes to pointer values 0x10 and above are acknowledged and then discarded. Pointer values 0x13 and above read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level, asynchronous |
| sda_in | input | 1 | Serial data line level, asynchronous |
| strap_lvl | input | 2 | Address strap level: 00 low, 01 high, 1x floating |
| vco_stat | input | 8 | Status byte shown at register 0x11 |
| gen_stat | input | 8 | Status byte shown at register 0x12 |
| sda_pull | output | 1 | When 1, the pad pulls SDA low |
| reg_flat | output | NUM_RW*8 | Contents of all writable registers |

## Verification
The bench builds the block with its default parameters: 16 writable registers, a 13-entry ROM and a base address of 0x30. With these values every ROM index can be reached, including the unimplemented indices 13 to 15. Bursts can also cross the boundary from the last writable register into the read-only window and then past the last implemented address. Each of the three strap levels is tried against both matching and non-matching addresses. Burst reads end with a NACK after one to four bytes.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_WR, ST_ACK, ST_RD, ST_MACK
  } i2cr_st_e;

  // Calibration content: a small affine sequence, zero past the depth.
  function automatic logic [7:0] cal_rom_byte(input logic [3:0] idx, input int depth);
    logic [7:0] v;
    v = 8'(({4'd0, idx} * 8'd37) + 8'd27);
    return (int'(idx) < depth) ? v : 8'h00;
  endfunction

endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_hi,
  output logic sda_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] scl_m, sda_m;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_in};
      sda_m <= {sda_m[0], sda_in};
      scl_q <= scl_m[1];
      sda_q <= sda_m[1];
    end
  end

  assign scl_hi   = scl_m[1];
  assign sda_hi   = sda_m[1];
  assign scl_rise = scl_m[1] & ~scl_q;
  assign scl_fall = ~scl_m[1] & scl_q;
  assign start_ev = scl_m[1] & scl_q & sda_q & ~sda_m[1];
  assign stop_ev  = scl_m[1] & scl_q & ~sda_q & sda_m[1];

endmodule

// File: rtl/i2cr_regbank.sv
module i2cr_regbank #(
  parameter int NUM_RW     = 16,
  parameter int ROM_DEPTH  = 13,
  parameter int ROMSEL_IDX = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [7:0]          rd_addr,
  input  logic [7:0]          vco_stat,
  input  logic [7:0]          gen_stat,
  output logic [7:0]          rd_data,
  output logic [NUM_RW*8-1:0] reg_flat
);
  import i2cr_pkg::*;

  localparam int IW       = $clog2(NUM_RW);
  localparam int ADDR_ROM = NUM_RW;
  localparam int ADDR_VCO = NUM_RW + 1;
  localparam int ADDR_GEN = NUM_RW + 2;

  logic [7:0] regs [NUM_RW];
  logic [7:0] rom_tab [16];
  logic [7:0] rom_q;
  logic [3:0] sel;

  for (genvar i = 0; i < 16; i++) begin : g_rom
    assign rom_tab[i] = cal_rom_byte(4'(i), ROM_DEPTH);
  end

  for (genvar r = 0; r < NUM_RW; r++) begin : g_flat
    assign reg_flat[8*r +: 8] = regs[r];
  end

  assign sel = regs[ROMSEL_IDX][3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_RW; r++) regs[r] <= 8'h00;
      rom_q <= cal_rom_byte(4'd0, ROM_DEPTH);
    end else begin
      if (wr_en && (wr_addr < 8'(NUM_RW))) regs[wr_addr[IW-1:0]] <= wr_data;
      rom_q <= rom_tab[sel];
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr < 8'(NUM_RW))        rd_data = regs[rd_addr[IW-1:0]];
    else if (rd_addr == 8'(ADDR_ROM)) rd_data = rom_q;
    else if (rd_addr == 8'(ADDR_VCO)) rd_data = vco_stat;
    else if (rd_addr == 8'(ADDR_GEN)) rd_data = gen_stat;
  end

  assert_rw_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr < 8'(NUM_RW))) |=> (regs[$past(wr_addr[IW-1:0])] == $past(wr_data)));

  assert_rom_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(sel) |=> $stable(rom_q));

endmodule

// File: rtl/i2cr_slave.sv
module i2cr_slave #(
  parameter logic [6:0] BASE_ADDR  = 7'h30,
  parameter int         NUM_RW     = 16,
  parameter int         ROM_DEPTH  = 13,
  parameter int         ROMSEL_IDX = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_in,
  input  logic                sda_in,
  input  logic [1:0]          strap_lvl,
  input  logic [7:0]          vco_stat,
  input  logic [7:0]          gen_stat,
  output logic                sda_pull,
  output logic [NUM_RW*8-1:0] reg_flat
);
  import i2cr_pkg::*;

  logic scl_hi, sda_hi, scl_rise, scl_fall, start_ev, stop_ev;
  i2cr_st_e   st, nxt;
  logic [3:0] cnt;
  logic [7:0] sh, ptr, rd_data;
  logic       nack;
  logic [6:0] my_addr;
  logic       wr_en;

  i2cr_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_hi(scl_hi), .sda_hi(sda_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2cr_regbank #(.NUM_RW(NUM_RW), .ROM_DEPTH(ROM_DEPTH), .ROMSEL_IDX(ROMSEL_IDX)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr), .wr_data(sh),
    .rd_addr(ptr), .vco_stat(vco_stat), .gen_stat(gen_stat),
    .rd_data(rd_data), .reg_flat(reg_flat)
  );

  always_comb begin
    case (strap_lvl)
      2'b00:   my_addr = BASE_ADDR;
      2'b01:   my_addr = BASE_ADDR | 7'd1;
      default: my_addr = BASE_ADDR | 7'd2;
    endcase
  end

  assign wr_en = (st == ST_WR) && scl_fall && (cnt == 4'd8) && !start_ev && !stop_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; nxt <= ST_IDLE; cnt <= '0; sh <= '0;
      ptr <= '0; nack <= 1'b0; sda_pull <= 1'b0;
    end else if (start_ev) begin
      st <= ST_ADDR; cnt <= '0; sda_pull <= 1'b0;
    end else if (stop_ev) begin
      st <= ST_IDLE; sda_pull <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_PTR, ST_WR: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_hi};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (st == ST_ADDR) begin
              if (sh[7:1] == my_addr) begin
                sda_pull <= 1'b1; st <= ST_ACK;
                nxt <= sh[0] ? ST_RD : ST_PTR;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              if (st == ST_PTR) ptr <= sh;
              else              ptr <= ptr + 8'd1;
              sda_pull <= 1'b1; st <= ST_ACK; nxt <= ST_WR;
            end
          end
        end
        ST_ACK: if (scl_fall) begin
          st <= nxt; cnt <= '0;
          if (nxt == ST_RD) begin
            sh <= rd_data; sda_pull <= ~rd_data[7];
          end else begin
            sda_pull <= 1'b0;
          end
        end
        ST_RD: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_pull <= 1'b0; st <= ST_MACK; ptr <= ptr + 8'd1;
            end else begin
              sh <= {sh[6:0], 1'b0}; sda_pull <= ~sh[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) nack <= sda_hi;
          else if (scl_fall) begin
            if (nack) st <= ST_IDLE;
            else begin
              sh <= rd_data; sda_pull <= ~rd_data[7]; st <= ST_RD; cnt <= '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_pull);

  assert_pull_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_hi);

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == $past(ptr) + 8'd1));

  assert_start_rearm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == ST_ADDR && !sda_pull));

endmodule

// File: tb/sim_i2cr_slave.sv
module sim_i2cr_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic [1:0] strap_lvl = 2'b00;
  logic [7:0] vco_stat = 8'h00, gen_stat = 8'h00;
  logic sda_pull;
  logic [127:0] reg_flat;
  wire sda_line = sda_drv & ~sda_pull;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] got [8];

  always #10 clk = ~clk;

  i2cr_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line),
    .strap_lvl(strap_lvl), .vco_stat(vco_stat), .gen_stat(gen_stat),
    .sda_pull(sda_pull), .reg_flat(reg_flat)
  );

  function automatic logic [7:0] exp_rom(input int i);
    return (i < 13) ? 8'((i * 37 + 27) % 256) : 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q(); repeat (8) @(negedge clk); endtask

  task automatic bus_start();
    sda_drv = 1; q(); scl_drv = 1; q(); sda_drv = 0; q(); scl_drv = 0; q();
  endtask

  task automatic bus_stop();
    sda_drv = 0; q(); scl_drv = 1; q(); sda_drv = 1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; q(); scl_drv = 1; q(); q(); scl_drv = 0; q();
    end
    sda_drv = 1; q(); scl_drv = 1; q();
    acked = ~sda_line;
    q(); scl_drv = 0; q();
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] b);
    sda_drv = 1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_drv = 1; q(); b[i] = sda_line; q(); scl_drv = 0;
    end
    q(); sda_drv = last; q(); scl_drv = 1; q(); q(); scl_drv = 0; q();
    sda_drv = 1;
  endtask

  task automatic write_regs(input logic [6:0] sa, input logic [7:0] p,
                            input logic [7:0] d [4], input int n, input string req);
    logic a;
    bus_start();
    send_byte({sa, 1'b0}, a); check({req, " addr ack"}, a, 1);
    send_byte(p, a);          check({req, " ptr ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a);     check({req, " data ack"}, a, 1);
    end
    bus_stop();
  endtask

  task automatic read_regs(input logic [6:0] sa, input logic [7:0] p, input int n);
    logic a;
    bus_start();
    send_byte({sa, 1'b0}, a); check("R4 addr ack", a, 1);
    send_byte(p, a);          check("R4 ptr ack", a, 1);
    bus_start();
    send_byte({sa, 1'b1}, a); check("R4 read addr ack", a, 1);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, got[i]);
    bus_stop();
  endtask

  task automatic t_reset();
    check("R1 pull after reset", sda_pull, 0);
    check("R1 regs after reset", reg_flat[31:0], 0);
    check("R1 regs high after reset", reg_flat[127:96], 0);
  endtask

  task automatic t_write_read();
    logic [7:0] d [4];
    d = '{8'hA1, 8'h5E, 8'h00, 8'hFF};
    write_regs(7'h30, 8'h02, d, 4, "R3");
    check("R5 reg2", reg_flat[23:16], 8'hA1);
    check("R5 reg3", reg_flat[31:24], 8'h5E);
    check("R5 reg5", reg_flat[47:40], 8'hFF);
    read_regs(7'h30, 8'h02, 4);
    check("R4 burst b0", got[0], 8'hA1);
    check("R4 burst b1", got[1], 8'h5E);
    check("R4 burst b2", got[2], 8'h00);
    check("R4 burst b3", got[3], 8'hFF);
    read_regs(7'h30, 8'h03, 1);
    check("R4 single", got[0], 8'h5E);
  endtask

  task automatic t_strap();
    logic a;
    logic [7:0] d [4];
    d = '{8'h77, 8'h00, 8'h00, 8'h00};
    strap_lvl = 2'b01; q();
    bus_start(); send_byte({7'h30, 1'b0}, a); bus_stop();
    check("R2 high strap rejects +0", a, 0);
    // unaddressed bytes must not land in register 2
    bus_start(); send_byte({7'h32, 1'b0}, a); send_byte(8'h02, a);
    send_byte(8'h99, a); bus_stop();
    check("R2 foreign write ignored", reg_flat[23:16], 8'hA1);
    write_regs(7'h31, 8'h07, d, 1, "R2 high strap");
    check("R2 high strap write", reg_flat[63:56], 8'h77);
    strap_lvl = 2'b10; q();
    bus_start(); send_byte({7'h31, 1'b0}, a); bus_stop();
    check("R2 float strap rejects +1", a, 0);
    d[0] = 8'h3C;
    write_regs(7'h32, 8'h07, d, 1, "R2 float strap");
    check("R2 float strap write", reg_flat[63:56], 8'h3C);
    strap_lvl = 2'b00; q();
    bus_start(); send_byte({7'h32, 1'b0}, a); bus_stop();
    check("R2 low strap rejects +2", a, 0);
  endtask

  task automatic t_rom();
    logic [7:0] d [4];
    int idx [5] = '{0, 5, 12, 13, 15};
    d = '{8'h00, 8'h00, 8'h00, 8'h00};
    for (int k = 0; k < 5; k++) begin
      d[0] = 8'(idx[k]);
      write_regs(7'h30, 8'h0E, d, 1, "R6 sel");
      read_regs(7'h30, 8'h10, 1);
      check($sformatf("R6 rom idx %0d", idx[k]), got[0], exp_rom(idx[k]));
    end
  endtask

  task automatic t_status();
    vco_stat = 8'h5C; gen_stat = 8'h07;
    read_regs(7'h30, 8'h0F, 4);
    check("R6 rom at 0x10 in burst", got[1], exp_rom(15));
    check("R7 vco status", got[2], 8'h5C);
    check("R7 gen status", got[3], 8'h07);
    vco_stat = 8'hE1;
    read_regs(7'h30, 8'h11, 1);
    check("R7 vco status live", got[0], 8'hE1);
  endtask

  task automatic t_readonly();
    logic [7:0] d [4];
    d = '{8'h04, 8'hFF, 8'hAA, 8'hBB};
    write_regs(7'h30, 8'h0E, d, 4, "R8 write across RO");
    read_regs(7'h30, 8'h10, 4);
    check("R8 rom reg unchanged", got[0], exp_rom(4));
    check("R8 vco reg unchanged", got[1], 8'hE1);
    check("R8 gen reg unchanged", got[2], 8'h07);
    check("R8 past end reads zero", got[3], 8'h00);
    read_regs(7'h30, 8'hC0, 2);
    check("R8 high ptr zero", got[0] | got[1], 8'h00);
    check("R8 writable regs intact", reg_flat[63:56], 8'h3C);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_read();
    t_strap();
    t_rom();
    t_status();
    t_readonly();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule